// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the bus-side protocol engine of a byte-wide serial memory with 32K locations that answers as a target on a two-wire bus. It takes SCL and SDA samples that are already synchronised to the system clock. It drives a single pull-down enable for the open-drain SDA line. It recognises bus START and STOP conditions. It checks each control byte against a fixed device code and three strap inputs, and it acknowledges every byte it receives once it has been addressed.

The block holds one 15-bit pointer, which writes and reads share. A write transaction loads the pointer from two address bytes. Each following data byte is handed, together with its address, to a separate page-commit engine through a one-cycle strobe. A STOP that closes a write with at least one data byte produces a commit pulse. The block supports three kinds of read: current-address reads, random reads made with a repeated START, and sequential reads. Read data comes from an asynchronous array read port that is addressed by the pointer. While the commit engine reports a write in progress, the block acknowledges nothing.

Top module: `ee2w_target`

## Requirements
- R1: A falling SDA while SCL is high is a START, and it always restarts control-byte reception. A rising SDA while SCL is high is a STOP, and it always returns the block to idle. Either condition abandons any partly received byte, and the block releases SDA.
- R2: A control byte is accepted only when bits 7:4 equal 4'b1010 and bits 3:1 equal `strap_i[2:0]`. Bit 0 selects the operation, with 1 meaning read. An accepted byte is acknowledged by pulling SDA low through the ninth clock. Any other byte gets no acknowledge, and all bus traffic is then ignored until the next START.
- R3: While `wr_busy_i` is high, no control byte is acknowledged, even one that matches.
- R4: After a write control byte, the block receives two address bytes, high byte first. Bit 7 of the high byte is ignored. Every data byte that follows is acknowledged and appears for exactly one cycle on `wbyte_valid_o`, with its address and its value.
- R5: After each write data byte, only the low 6 bits of the pointer advance. They wrap inside the 64-byte page, and the upper bits are left as they are.
- R6: A STOP that ends a write with at least one data byte gives a one-cycle `commit_o` pulse. A STOP after a read, or after an address-only write, gives none.
- R7: A read with no preceding address phase returns the byte at the pointer. After every access the pointer holds the last accessed address plus one. The pointer resets to 0.
- R8: A write control byte followed by two address bytes, then a repeated START and a read control byte, returns the byte at the newly loaded address.
- R9: During a read, a controller ACK makes the block send the next byte, and the pointer goes from 0x7FFF to 0x0000. A controller NACK makes the block release SDA and go idle.
- R10: The SDA pull-down starts only on a cycle where SCL was sampled low.
- R11: The array read address never changes while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample (wired bus level) |
| strap_i | input | 3 | Device select straps |
| wr_busy_i | input | 1 | Internal write cycle in progress |
| mem_rdata_i | input | 8 | Array data at `mem_raddr_o` (asynchronous read) |
| sda_pull_o | output | 1 | Drive SDA low when 1 |
| mem_raddr_o | output | 15 | Array read address (current pointer) |
| wbyte_valid_o | output | 1 | One-cycle strobe for a received write byte |
| wbyte_addr_o | output | 15 | Address of the strobed write byte |
| wbyte_data_o | output | 8 | Value of the strobed write byte |
| commit_o | output | 1 | One-cycle pulse on a STOP that closes a write |

## Verification
The bench builds the block with its default parameters: a 15-bit address and a 6-bit page offset. With these, the page wrap can be reached by three data bytes written from offset 0x3E. The array-top rollover can be reached by three sequential reads from 0x7FFE. The array model in the bench is a computed function of the address, so every read value can be predicted without storage. The bench also runs the busy refusal, strap and code mismatches, and START or STOP inside a byte.

// File: rtl/ee2w_pkg.sv
package ee2w_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_ACK,
        ST_TX,
        ST_TXACK
    } st_e;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/ee2w_busmon.sv
module ee2w_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        start_o = scl_i & scl_q & sda_q & ~sda_i;
        stop_o  = scl_i & scl_q & ~sda_q & sda_i;
        rise_o  = scl_i & ~scl_q;
        fall_o  = ~scl_i & scl_q;
    end
endmodule

// File: rtl/ee2w_match.sv
module ee2w_match #(
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic [7:0] byte_i,
    input  logic [2:0] strap_i,
    input  logic       busy_i,
    output logic       hit_o,
    output logic       rd_o
);
    always_comb begin
        hit_o = (byte_i[7:4] == DEV_CODE) && (byte_i[3:1] == strap_i) && !busy_i;
        rd_o  = byte_i[0];
    end
endmodule

// File: rtl/ee2w_ptr_step.sv
module ee2w_ptr_step #(
    parameter int ADDR_W = 15,
    parameter int PAGE_W = 6
) (
    input  logic [ADDR_W-1:0] ptr_i,
    output logic [ADDR_W-1:0] seq_next_o,
    output logic [ADDR_W-1:0] page_next_o
);
    always_comb seq_next_o = ptr_i + 1'b1;

    generate
        if (PAGE_W >= ADDR_W) begin : g_whole
            always_comb page_next_o = ptr_i + 1'b1;
        end else begin : g_page
            always_comb page_next_o = {ptr_i[ADDR_W-1:PAGE_W], ptr_i[PAGE_W-1:0] + 1'b1};
        end
    endgenerate
endmodule

// File: rtl/ee2w_target.sv
module ee2w_target #(
    parameter int         ADDR_W   = 15,
    parameter int         PAGE_W   = 6,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap_i,
    input  logic              wr_busy_i,
    input  logic [7:0]        mem_rdata_i,
    output logic              sda_pull_o,
    output logic [ADDR_W-1:0] mem_raddr_o,
    output logic              wbyte_valid_o,
    output logic [ADDR_W-1:0] wbyte_addr_o,
    output logic [7:0]        wbyte_data_o,
    output logic              commit_o
);
    import ee2w_pkg::*;

    localparam int HI_W = ADDR_W - BYTE_W;

    typedef struct packed {
        st_e               state;
        st_e               nxt;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [HI_W-1:0]   ahi;
        logic [ADDR_W-1:0] ptr;
        logic              pull;
        logic              mack;
        logic              wr_open;
        logic              wvalid;
        logic [ADDR_W-1:0] waddr;
        logic [7:0]        wdata;
        logic              commit;
    } regs_t;

    regs_t r_q, r_d;

    logic start_w, stop_w, rise_w, fall_w;
    logic hit_w, rd_w;
    logic [ADDR_W-1:0] seq_next_w, page_next_w;

    ee2w_busmon u_busmon (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .start_o (start_w),
        .stop_o  (stop_w),
        .rise_o  (rise_w),
        .fall_o  (fall_w)
    );

    ee2w_match #(.DEV_CODE(DEV_CODE)) u_match (
        .byte_i  (r_q.sh),
        .strap_i (strap_i),
        .busy_i  (wr_busy_i),
        .hit_o   (hit_w),
        .rd_o    (rd_w)
    );

    ee2w_ptr_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
        .ptr_i       (r_q.ptr),
        .seq_next_o  (seq_next_w),
        .page_next_o (page_next_w)
    );

    always_comb begin
        r_d        = r_q;
        r_d.wvalid = 1'b0;
        r_d.commit = 1'b0;
        if (stop_w) begin
            r_d.state   = ST_IDLE;
            r_d.pull    = 1'b0;
            r_d.cnt     = '0;
            r_d.commit  = r_q.wr_open;
            r_d.wr_open = 1'b0;
        end else if (start_w) begin
            r_d.state   = ST_CTRL;
            r_d.pull    = 1'b0;
            r_d.cnt     = '0;
            r_d.wr_open = 1'b0;
        end else begin
            case (r_q.state)
                ST_CTRL, ST_AHI, ST_ALO, ST_WDAT: begin
                    if (rise_w && r_q.cnt < 4'd8) begin
                        r_d.sh  = {r_q.sh[6:0], sda_i};
                        r_d.cnt = r_q.cnt + 4'd1;
                    end
                    if (fall_w && r_q.cnt == 4'd8) begin
                        r_d.cnt   = '0;
                        r_d.state = ST_ACK;
                        r_d.pull  = 1'b1;
                        case (r_q.state)
                            ST_CTRL: begin
                                if (hit_w) begin
                                    r_d.nxt = rd_w ? ST_TX : ST_AHI;
                                end else begin
                                    r_d.state = ST_IDLE;
                                    r_d.pull  = 1'b0;
                                end
                            end
                            ST_AHI: begin
                                r_d.ahi = r_q.sh[HI_W-1:0];
                                r_d.nxt = ST_ALO;
                            end
                            ST_ALO: begin
                                r_d.ptr = {r_q.ahi, r_q.sh};
                                r_d.nxt = ST_WDAT;
                            end
                            default: begin
                                r_d.wvalid  = 1'b1;
                                r_d.waddr   = r_q.ptr;
                                r_d.wdata   = r_q.sh;
                                r_d.ptr     = page_next_w;
                                r_d.wr_open = 1'b1;
                                r_d.nxt     = ST_WDAT;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (fall_w) begin
                        r_d.pull  = 1'b0;
                        r_d.state = r_q.nxt;
                        r_d.cnt   = '0;
                        if (r_q.nxt == ST_TX) begin
                            r_d.sh   = mem_rdata_i;
                            r_d.pull = ~mem_rdata_i[7];
                            r_d.ptr  = seq_next_w;
                        end
                    end
                end
                ST_TX: begin
                    if (fall_w) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.pull  = 1'b0;
                            r_d.state = ST_TXACK;
                            r_d.cnt   = '0;
                        end else begin
                            r_d.sh   = {r_q.sh[6:0], 1'b0};
                            r_d.pull = ~r_q.sh[6];
                            r_d.cnt  = r_q.cnt + 4'd1;
                        end
                    end
                end
                ST_TXACK: begin
                    if (rise_w) r_d.mack = ~sda_i;
                    if (fall_w) begin
                        if (r_q.mack) begin
                            r_d.state = ST_TX;
                            r_d.cnt   = '0;
                            r_d.sh    = mem_rdata_i;
                            r_d.pull  = ~mem_rdata_i[7];
                            r_d.ptr   = seq_next_w;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, nxt: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_pull_o    = r_q.pull;
    assign mem_raddr_o   = r_q.ptr;
    assign wbyte_valid_o = r_q.wvalid;
    assign wbyte_addr_o  = r_q.waddr;
    assign wbyte_data_o  = r_q.wdata;
    assign commit_o      = r_q.commit;
endmodule

// File: rtl/ee2w_target_chk.sv
module ee2w_target_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_pull_o,
    input logic [ADDR_W-1:0] mem_raddr_o,
    input logic              wbyte_valid_o,
    input logic              commit_o
);
    assert_pull_after_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !$past(scl_i));

    assert_ptr_still_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(mem_raddr_o));

    assert_wbyte_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wbyte_valid_o |=> !wbyte_valid_o);

    assert_commit_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(scl_i) && $past(sda_i) && !$past(sda_i, 2)));

    assert_commit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
endmodule

bind ee2w_target ee2w_target_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_i),
    .sda_i         (sda_i),
    .sda_pull_o    (sda_pull_o),
    .mem_raddr_o   (mem_raddr_o),
    .wbyte_valid_o (wbyte_valid_o),
    .commit_o      (commit_o)
);

// File: tb/ee2w_target_bench.sv
`timescale 1ns/1ps
module ee2w_target_bench;
    localparam int AW = 15;
    localparam int Q  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic wr_busy = 1'b0;
    logic [2:0] strap = 3'b101;
    logic sda_pull;
    logic [AW-1:0] raddr;
    logic [7:0] rdata;
    logic wvalid, commit;
    logic [AW-1:0] waddr;
    logic [7:0] wdata;
    logic sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign sda_bus = m_sda & ~sda_pull;

    function automatic logic [7:0] mdat(input logic [AW-1:0] a);
        return a[7:0] ^ {a[14:8], 1'b0} ^ 8'h5A;
    endfunction

    assign rdata = mdat(raddr);

    ee2w_target u_ee2w_target (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (m_scl),
        .sda_i         (sda_bus),
        .strap_i       (strap),
        .wr_busy_i     (wr_busy),
        .mem_rdata_i   (rdata),
        .sda_pull_o    (sda_pull),
        .mem_raddr_o   (raddr),
        .wbyte_valid_o (wvalid),
        .wbyte_addr_o  (waddr),
        .wbyte_data_o  (wdata),
        .commit_o      (commit)
    );

    // write strobe and commit logs, pin-level monitors
    logic [AW-1:0] wlog_a [16];
    logic [7:0]    wlog_d [16];
    int wcnt = 0;
    int ccnt = 0;
    int pull_hi_chg = 0;
    int addr_hi_chg = 0;
    logic prev_pull = 1'b0;
    logic prev_scl = 1'b1;
    logic [AW-1:0] prev_addr = '0;

    always @(posedge clk) begin
        if (rst_n) begin
            if (wvalid) begin
                wlog_a[wcnt[3:0]] <= waddr;
                wlog_d[wcnt[3:0]] <= wdata;
                wcnt <= wcnt + 1;
            end
            if (commit) ccnt <= ccnt + 1;
            if (m_scl && prev_scl && sda_pull && !prev_pull) pull_hi_chg <= pull_hi_chg + 1;
            if (m_scl && prev_scl && raddr != prev_addr) addr_hi_chg <= addr_hi_chg + 1;
        end
        prev_pull <= sda_pull;
        prev_scl  <= m_scl;
        prev_addr <= raddr;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wt(Q);
        m_scl = 1'b1; wt(Q);
        m_sda = 1'b1; wt(2 * Q);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; wt(Q);
        m_scl = 1'b1; wt(2 * Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        m_sda = 1'b1; wt(Q);
        m_scl = 1'b1; wt(Q);
        acked = (sda_bus == 1'b0);
        wt(Q);
        m_scl = 1'b0; wt(Q);
    endtask

    task automatic read_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(Q);
            m_scl = 1'b1; wt(Q);
            b[i] = sda_bus;
            wt(Q);
            m_scl = 1'b0;
        end
        wt(Q);
        m_sda = ~give_ack; wt(Q);
        m_scl = 1'b1; wt(2 * Q);
        m_scl = 1'b0; wt(Q);
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        check("reset R7 pointer", raddr, 15'h0);
        check("reset R10 pull", sda_pull, 1'b0);
        check("reset R4 strobe", wvalid, 1'b0);
        check("reset R6 commit", commit, 1'b0);
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte(8'hA6, a);            // strap bits 011 vs 101
        check("R2 strap mismatch nack", a, 1'b0);
        send_byte(8'hAA, a);            // matching byte but no START
        check("R2 ignored until START", a, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hBA, a);            // code 1011
        check("R2 code mismatch nack", a, 1'b0);
        bus_stop();
        check("R2 pointer untouched", raddr, 15'h0);
    endtask

    task automatic t_page_write();
        logic a;
        int w0, c0;
        w0 = wcnt; c0 = ccnt;
        bus_start();
        send_byte(8'hAA, a); check("R2 write control ack", a, 1'b1);
        send_byte(8'h92, a); check("R4 high address ack", a, 1'b1);
        send_byte(8'h3E, a); check("R4 low address ack", a, 1'b1);
        send_byte(8'h11, a); check("R4 data0 ack", a, 1'b1);
        send_byte(8'h22, a); check("R4 data1 ack", a, 1'b1);
        send_byte(8'h33, a); check("R4 data2 ack", a, 1'b1);
        check("R4 strobe count", wcnt - w0, 3);
        check("R6 no commit before STOP", ccnt - c0, 0);
        bus_stop();
        check("R6 commit pulse", ccnt - c0, 1);
        check("R4 addr0 bit7 ignored", wlog_a[w0], 15'h123E);
        check("R4 data0", wlog_d[w0], 8'h11);
        check("R5 addr1", wlog_a[w0 + 1], 15'h123F);
        check("R5 addr2 page wrap", wlog_a[w0 + 2], 15'h1200);
        check("R4 data2", wlog_d[w0 + 2], 8'h33);
        check("R7 pointer after write", raddr, 15'h1201);
    endtask

    task automatic t_busy();
        logic a;
        int w0, c0;
        w0 = wcnt; c0 = ccnt;
        wr_busy = 1'b1;
        bus_start();
        send_byte(8'hAA, a); check("R3 busy nack", a, 1'b0);
        send_byte(8'h00, a); check("R3 no follow-on ack", a, 1'b0);
        bus_stop();
        wr_busy = 1'b0;
        check("R3 no strobe while busy", wcnt - w0, 0);
        check("R6 no commit without data", ccnt - c0, 0);
    endtask

    task automatic t_current_read();
        logic a;
        logic [7:0] b;
        int c0;
        c0 = ccnt;
        bus_start();
        send_byte(8'hAB, a); check("R7 read control ack", a, 1'b1);
        read_byte(1'b0, b);
        check("R7 current-address data", b, mdat(15'h1201));
        check("R9 release after NACK", sda_pull, 1'b0);
        bus_stop();
        check("R6 no commit after read", ccnt - c0, 0);
        check("R7 pointer advanced", raddr, 15'h1202);
    endtask

    task automatic t_random_seq();
        logic a;
        logic [7:0] b;
        int c0;
        c0 = ccnt;
        bus_start();
        send_byte(8'hAA, a);
        send_byte(8'h7F, a);
        send_byte(8'hFE, a); check("R8 address ack", a, 1'b1);
        bus_start();
        send_byte(8'hAB, a); check("R8 read control ack", a, 1'b1);
        read_byte(1'b1, b); check("R8 random data", b, mdat(15'h7FFE));
        read_byte(1'b1, b); check("R9 sequential data", b, mdat(15'h7FFF));
        read_byte(1'b0, b); check("R9 wrap to 0000", b, mdat(15'h0000));
        check("R9 released after NACK", sda_pull, 1'b0);
        bus_stop();
        check("R6 address-only write no commit", ccnt - c0, 0);
        check("R9 pointer after wrap", raddr, 15'h0001);
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] b;
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        bus_start();
        send_byte(8'hAB, a); check("R1 START mid-byte restarts", a, 1'b1);
        read_byte(1'b0, b); check("R1 read after restart", b, mdat(15'h0001));
        bus_stop();
        bus_start();
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        bus_stop();
        send_byte(8'hAA, a); check("R1 STOP mid-byte idles", a, 1'b0);
        bus_stop();
        bus_start();
        send_byte(8'hAB, a);
        read_byte(1'b0, b); check("R1 pointer kept over abort", b, mdat(15'h0002));
        bus_stop();
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        wt(5);
        rst_n = 1'b1;
        wt(3);
        t_reset();
        t_mismatch();
        t_page_write();
        t_busy();
        t_current_read();
        t_random_seq();
        t_abort();
        wt(4);
        check("R10 pull begins only with SCL low", pull_hi_chg, 0);
        check("R11 address steady while SCL high", addr_hi_chg, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule